// File: doc/BRIEF.md
# Epoch-Aware Two-Way Victim Selector

This block picks the way to replace when a line is filled into a two-way set-associative cache. For every set it keeps a valid flag and a small epoch tag per way, plus one bit naming the most recently used way. The epoch tag is the age stamp that the address-hashing logic attaches to each access. It is recorded with the line when the line is filled.

The victim is chosen in a fixed order. An empty way is taken first. If both ways hold lines with different epochs, the line with the older (numerically smaller) epoch is evicted. This lets stale hash assignments drain out of the cache, so their entries can be given a new mapping. If the epochs are equal, the least recently used line is evicted. The victim output is combinational from the looked-up set index. Hits and fills update the stored state on the rising clock edge.

Top module: `epoch_victim_sel`

## Requirements
- R1: `victim_way_o` follows `lookup_set_i` combinationally, with no clock cycle of delay; 0 means way 0 and 1 means way 1.
- R2: In the looked-up set, if way 0 is invalid the victim is 0. If way 0 is valid and way 1 is invalid, the victim is 1.
- R3: When both ways are valid and their epoch tags differ, the victim is the way whose tag is smaller. The comparison is plain unsigned, with no wraparound, so tag 0 loses to tag 3.
- R4: When both ways are valid and their epoch tags are equal, the victim is the way that is not the most recently used way.
- R5: A hit (`hit_i`=1) makes `hit_way_i` the most recently used way of `hit_set_i` from the next clock edge onward.
- R6: A fill (`fill_i`=1) marks `fill_way_i` of `fill_set_i` valid, stores `fill_epoch_i` as its tag, and makes it the most recently used way, all at the next clock edge.
- R7: When a hit and a fill target the same set in the same cycle, the fill's way becomes the most recently used way.
- R8: Asserting `rst_ni` low clears every valid bit and every recency bit.
- R9: A hit or a fill in one set leaves the state of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_set_i | input | SET_W | Set whose victim is requested |
| victim_way_o | output | 1 | Way to replace in the looked-up set |
| hit_i | input | 1 | Hit update strobe |
| hit_set_i | input | SET_W | Set that was hit |
| hit_way_i | input | 1 | Way that was hit |
| fill_i | input | 1 | Fill strobe |
| fill_set_i | input | SET_W | Set being filled |
| fill_way_i | input | 1 | Way being filled |
| fill_epoch_i | input | EPOCH_W | Epoch tag of the incoming line |

## Verification
The properties assume that the strobes and indices are known, two-valued values in every cycle outside reset. They also assume that a hit is only reported for a way that is currently valid. The assertions do not depend on this second point, but it keeps the recency checks meaningful. The bench follows both rules. It drives every input on the falling edge, keeps the strobes low except within single update cycles, and issues hits only after both ways of a set have been filled. It uses a four-set configuration and sweeps every pair of epoch tags against both recency states.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic {
    WAY_0 = 1'b0,
    WAY_1 = 1'b1
  } way_e;
endpackage

// File: rtl/evs_line_store.sv
module evs_line_store #(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned EPOCH_W  = 2,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                fill_i,
  input  logic [SET_W-1:0]                    fill_set_i,
  input  logic                                fill_way_i,
  input  logic [EPOCH_W-1:0]                  fill_epoch_i,
  input  logic [SET_W-1:0]                    rd_set_i,
  output logic [1:0]                          rd_valid_o,
  output logic [1:0][EPOCH_W-1:0]             rd_epoch_o,
  output logic [NUM_SETS-1:0][1:0]            valid_all_o
);
  for (genvar w = 0; w < evs_pkg::NUM_WAYS; w++) begin : g_way
    logic [NUM_SETS-1:0]              valid_q;
    logic [NUM_SETS-1:0][EPOCH_W-1:0] epoch_q;
    logic                             wr_en;

    assign wr_en = fill_i && (fill_way_i == w[0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= '0;
      end else if (wr_en) begin
        valid_q[fill_set_i] <= 1'b1;
      end
    end

    // tags need no reset: they are qualified by valid
    always_ff @(posedge clk_i) begin
      if (wr_en) epoch_q[fill_set_i] <= fill_epoch_i;
    end

    assign rd_valid_o[w] = valid_q[rd_set_i];
    assign rd_epoch_o[w] = epoch_q[rd_set_i];

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      assign valid_all_o[s][w] = valid_q[s];
    end
  end
endmodule

// File: rtl/evs_lru_store.sv
module evs_lru_store #(
  parameter int unsigned NUM_SETS = 64,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hit_i,
  input  logic [SET_W-1:0]    hit_set_i,
  input  logic                hit_way_i,
  input  logic                fill_i,
  input  logic [SET_W-1:0]    fill_set_i,
  input  logic                fill_way_i,
  input  logic [SET_W-1:0]    rd_set_i,
  output logic                rd_mru_o,
  output logic [NUM_SETS-1:0] mru_all_o
);
  logic [NUM_SETS-1:0] mru_q;
  logic [NUM_SETS-1:0] mru_d;

  // fill is applied after hit so it wins on a shared set
  always_comb begin
    mru_d = mru_q;
    if (hit_i)  mru_d[hit_set_i]  = hit_way_i;
    if (fill_i) mru_d[fill_set_i] = fill_way_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mru_q <= '0;
    else         mru_q <= mru_d;
  end

  assign rd_mru_o  = mru_q[rd_set_i];
  assign mru_all_o = mru_q;
endmodule

// File: rtl/evs_pick.sv
module evs_pick #(
  parameter int unsigned EPOCH_W = 2
) (
  input  logic [1:0]              valid_i,
  input  logic [1:0][EPOCH_W-1:0] epoch_i,
  input  logic                    mru_i,
  output logic                    victim_o
);
  logic epoch_tie;
  logic way1_older;

  assign epoch_tie  = (epoch_i[0] == epoch_i[1]);
  assign way1_older = (epoch_i[1] < epoch_i[0]);

  always_comb begin
    if (!valid_i[0])     victim_o = evs_pkg::WAY_0;
    else if (!valid_i[1]) victim_o = evs_pkg::WAY_1;
    else if (!epoch_tie)  victim_o = way1_older;
    else                  victim_o = ~mru_i;
  end
endmodule

// File: rtl/epoch_victim_sel.sv
module epoch_victim_sel #(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned EPOCH_W  = 2,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SET_W-1:0]   lookup_set_i,
  output logic               victim_way_o,
  input  logic               hit_i,
  input  logic [SET_W-1:0]   hit_set_i,
  input  logic               hit_way_i,
  input  logic               fill_i,
  input  logic [SET_W-1:0]   fill_set_i,
  input  logic               fill_way_i,
  input  logic [EPOCH_W-1:0] fill_epoch_i
);
  logic [1:0]              rd_valid;
  logic [1:0][EPOCH_W-1:0] rd_epoch;
  logic                    rd_mru;
  logic [NUM_SETS-1:0][1:0] valid_all;
  logic [NUM_SETS-1:0]     mru_all;

  evs_line_store #(.NUM_SETS(NUM_SETS), .EPOCH_W(EPOCH_W)) u_lines (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_i       (fill_i),
    .fill_set_i   (fill_set_i),
    .fill_way_i   (fill_way_i),
    .fill_epoch_i (fill_epoch_i),
    .rd_set_i     (lookup_set_i),
    .rd_valid_o   (rd_valid),
    .rd_epoch_o   (rd_epoch),
    .valid_all_o  (valid_all)
  );

  evs_lru_store #(.NUM_SETS(NUM_SETS)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit_i),
    .hit_set_i  (hit_set_i),
    .hit_way_i  (hit_way_i),
    .fill_i     (fill_i),
    .fill_set_i (fill_set_i),
    .fill_way_i (fill_way_i),
    .rd_set_i   (lookup_set_i),
    .rd_mru_o   (rd_mru),
    .mru_all_o  (mru_all)
  );

  evs_pick #(.EPOCH_W(EPOCH_W)) u_pick (
    .valid_i  (rd_valid),
    .epoch_i  (rd_epoch),
    .mru_i    (rd_mru),
    .victim_o (victim_way_o)
  );
endmodule

// File: rtl/evs_checker.sv
module evs_checker #(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned EPOCH_W  = 2,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     victim_way_o,
  input logic                     hit_i,
  input logic [SET_W-1:0]         hit_set_i,
  input logic                     hit_way_i,
  input logic                     fill_i,
  input logic [SET_W-1:0]         fill_set_i,
  input logic                     fill_way_i,
  input logic [1:0]               rd_valid,
  input logic [1:0][EPOCH_W-1:0]  rd_epoch,
  input logic                     rd_mru,
  input logic [NUM_SETS-1:0][1:0] valid_all,
  input logic [NUM_SETS-1:0]      mru_all
);
  p_empty_way0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid[0] |-> victim_way_o == 1'b0);

  p_empty_way1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid[0] && !rd_valid[1]) |-> victim_way_o == 1'b1);

  p_older_epoch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&rd_valid && rd_epoch[0] != rd_epoch[1]) |->
      rd_epoch[victim_way_o] < rd_epoch[~victim_way_o]);

  p_tie_lru_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&rd_valid && rd_epoch[0] == rd_epoch[1]) |-> victim_way_o != rd_mru);

  p_hit_mru_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !(fill_i && fill_set_i == hit_set_i)) |=>
      mru_all[$past(hit_set_i)] == $past(hit_way_i));

  p_fill_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_all[$past(fill_set_i)][$past(fill_way_i)]);

  p_fill_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> mru_all[$past(fill_set_i)] == $past(fill_way_i));
endmodule

bind epoch_victim_sel evs_checker #(.NUM_SETS(NUM_SETS), .EPOCH_W(EPOCH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .victim_way_o (victim_way_o),
  .hit_i        (hit_i),
  .hit_set_i    (hit_set_i),
  .hit_way_i    (hit_way_i),
  .fill_i       (fill_i),
  .fill_set_i   (fill_set_i),
  .fill_way_i   (fill_way_i),
  .rd_valid     (rd_valid),
  .rd_epoch     (rd_epoch),
  .rd_mru       (rd_mru),
  .valid_all    (valid_all),
  .mru_all      (mru_all)
);

// File: tb/epoch_victim_sel_tb.sv
`timescale 1ns/1ps
module epoch_victim_sel_tb;
  localparam int unsigned NUM_SETS = 4;
  localparam int unsigned EPOCH_W  = 2;
  localparam int unsigned SET_W    = $clog2(NUM_SETS);

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [SET_W-1:0]   lookup_set_i = '0;
  logic               victim_way_o;
  logic               hit_i = 1'b0;
  logic [SET_W-1:0]   hit_set_i = '0;
  logic               hit_way_i = 1'b0;
  logic               fill_i = 1'b0;
  logic [SET_W-1:0]   fill_set_i = '0;
  logic               fill_way_i = 1'b0;
  logic [EPOCH_W-1:0] fill_epoch_i = '0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  epoch_victim_sel #(.NUM_SETS(NUM_SETS), .EPOCH_W(EPOCH_W)) u_dut (.*);

  task automatic check(input int set, input logic exp, input string req);
    lookup_set_i = set[SET_W-1:0];
    #1;
    checks++;
    if (victim_way_o !== exp) begin
      errors++;
      $display("FAIL %s set %0d: victim %0b expected %0b", req, set, victim_way_o, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    hit_i  = 1'b0;
    fill_i = 1'b0;
  endtask

  task automatic do_fill(input int set, input logic way, input int ep);
    fill_i = 1'b1; fill_set_i = set[SET_W-1:0]; fill_way_i = way;
    fill_epoch_i = ep[EPOCH_W-1:0];
    step();
  endtask

  task automatic do_hit(input int set, input logic way);
    hit_i = 1'b1; hit_set_i = set[SET_W-1:0]; hit_way_i = way;
    step();
  endtask

  task automatic do_both(input int set, input logic fway, input int ep, input logic hway);
    hit_i = 1'b1; hit_set_i = set[SET_W-1:0]; hit_way_i = hway;
    fill_i = 1'b1; fill_set_i = set[SET_W-1:0]; fill_way_i = fway;
    fill_epoch_i = ep[EPOCH_W-1:0];
    step();
  endtask

  task automatic apply_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    apply_reset();
    // R8 R2: all sets empty after reset
    for (int s = 0; s < NUM_SETS; s++) check(s, 1'b0, "R8");

    // R2: only way 1 valid -> way 0; only way 0 valid -> way 1
    do_fill(0, 1'b1, 2);
    check(0, 1'b0, "R2");
    do_fill(1, 1'b0, 3);
    check(1, 1'b1, "R2");

    // R1: output follows lookup index without a clock
    lookup_set_i = 1; #0.5;
    lookup_set_i = 0; #0.5;
    checks++;
    if (victim_way_o !== 1'b0) begin
      errors++; $display("FAIL R1: victim %0b expected 0", victim_way_o);
    end

    // R3 R4 R5 R6: sweep epoch pairs and recency in set 1
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int m = 0; m < 2; m++) begin
          logic exp;
          do_fill(1, 1'b0, a);
          do_fill(1, 1'b1, b);
          do_hit(1, m[0]);
          exp = (a != b) ? (b < a) : ~m[0];
          check(1, exp, (a != b) ? "R3" : "R4_R5");
        end
      end
    end

    // R9: untouched sets keep their state
    check(2, 1'b0, "R9");
    check(0, 1'b0, "R9");

    // R6: fill alone sets recency, tie epochs
    do_fill(3, 1'b0, 1);
    do_fill(3, 1'b1, 1);
    check(3, 1'b0, "R6");
    // R7: fill way 0 with simultaneous hit way 1 -> way 0 is MRU
    do_both(3, 1'b0, 1, 1'b1);
    check(3, 1'b1, "R7");
    do_both(3, 1'b1, 1, 1'b0);
    check(3, 1'b0, "R7");
    // R6: refill with newer epoch changes the choice
    do_fill(3, 1'b0, 3);
    check(3, 1'b1, "R6");

    // R8: reset mid-run clears valid bits
    apply_reset();
    for (int s = 0; s < NUM_SETS; s++) check(s, 1'b0, "R8");
    do_fill(3, 1'b0, 0);
    check(3, 1'b1, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule